// File: doc/BRIEF.md
# Nibble-Multiplexed Converter Word Link

This block joins a modem core to an external data converter over a narrow
four-line bus in each direction. On the transmit side it takes a 16-bit sample
from the transmit front-end once every four master-clock cycles. It sends that
sample as four nibbles on consecutive cycles, starting with the most
significant nibble. A word-marker strobe travels with the first nibble of each
word.

On the receive side it rebuilds 16-bit samples from incoming nibbles. It uses
the incoming marker to find where each word begins and checks that the marker
comes back every four cycles. When the marker arrives early or fails to arrive,
the block raises a one-cycle alignment error, discards the partial word and
aligns again. A test selector can feed the block's own transmit nibbles and
marker into the receive path in place of the external lines.

Top module: `nib_word_link`

## Requirements
- R1: While reset is held and in the first cycle after it is held, the transmit nibble, the transmit marker, the receive valid, the receive word and the alignment error are all zero.
- R2: `tx_fetch_o` is high in the first cycle after reset is released and then exactly once every 4 cycles. The word on `tx_word_i` is taken at the clock edge that ends a fetch cycle.
- R3: The word taken at a fetch edge appears on `cnv_txd_o` over the next 4 cycles in the order bits 15:12, 11:8, 7:4, 3:0. `cnv_tx_mark_o` is high only in the cycle that carries bits 15:12.
- R4: While `loop_sel_i` is 1, the receive path takes its nibble and marker from the block's own `cnv_txd_o` and `cnv_tx_mark_o`, and the external receive lines have no effect. Transmitted words then come back unchanged on `rx_word_o`.
- R5: A nibble captured together with the receive marker becomes bits 15:12 of a word. The next three nibbles become bits 11:8, 7:4 and 3:0. `rx_valid_o` is high with the complete word on `rx_word_o` in the cycle after the fourth nibble is captured.
- R6: After reset, no word is output until a receive marker has been captured.
- R7: A marker that arrives while a word is partly gathered makes `rx_align_err_o` high for one cycle, with no word output. The partial word is dropped and a new word starts from that marker's nibble.
- R8: If a nibble arrives without a marker in the cycle where the next word's marker is due, `rx_align_err_o` is high for one cycle. The receiver then outputs no word until a new marker arrives.
- R9: `rx_valid_o` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_word_i | input | 16 | Sample from the transmit front-end |
| tx_fetch_o | output | 1 | High in the cycle whose closing edge takes `tx_word_i` |
| cnv_txd_o | output | 4 | Transmit nibble to the converter |
| cnv_tx_mark_o | output | 1 | Transmit word marker, with the first nibble |
| cnv_rxd_i | input | 4 | Receive nibble from the converter |
| cnv_rx_mark_i | input | 1 | Receive word marker from the converter |
| loop_sel_i | input | 1 | 1 selects the internal loopback as receive source |
| rx_word_o | output | 16 | Rebuilt receive word |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_word_o` |
| rx_align_err_o | output | 1 | One-cycle marker alignment error |

## Verification
If the transmit phase counter held a wrong value, the fetch strobe and the
marker would leave their four-cycle grid. A reference that counts cycles from
reset would see this within four cycles. A wrong receive phase or lock state
would show, at the latest at the next marker, as a missing word, a spurious
alignment error or a word with rotated nibbles. Because the bench compares
every output on every cycle against a model built from the requirements, any
such fault is reported in the first cycle where it shows at a port.

// File: rtl/nib_link_pkg.sv
package nib_link_pkg;

   // receiver alignment mode
   typedef enum logic {
      RX_HUNT  = 1'b0,   // waiting for a marker
      RX_TRACK = 1'b1    // aligned, gathering nibbles
   } rx_mode_e;

endpackage

// File: rtl/nib_tx_serializer.sv
module nib_tx_serializer #(
   parameter int WORD_W = 16,
   parameter int LANE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word_i,
   output logic              fetch_o,
   output logic [LANE_W-1:0] nib_o,
   output logic              mark_o
);
   localparam int LANES = WORD_W / LANE_W;
   localparam int PH_W  = $clog2(LANES);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(LANES - 1);

   logic [PH_W-1:0]   ph_q;
   logic [WORD_W-1:0] sh_q;

   // fetch on the last slot so the new word's top nibble leaves next cycle
   assign fetch_o = (ph_q == PH_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_LAST;
         sh_q   <= '0;
         nib_o  <= '0;
         mark_o <= 1'b0;
      end else if (fetch_o) begin
         ph_q   <= '0;
         nib_o  <= word_i[WORD_W-1 -: LANE_W];
         sh_q   <= word_i << LANE_W;
         mark_o <= 1'b1;
      end else begin
         ph_q   <= ph_q + 1'b1;
         nib_o  <= sh_q[WORD_W-1 -: LANE_W];
         sh_q   <= sh_q << LANE_W;
         mark_o <= 1'b0;
      end
   end

   // R3: marker follows every fetch edge
   p_mark_after_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_o |=> mark_o);
   // R2: fetches are never adjacent
   p_fetch_apart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_o |=> !fetch_o);

endmodule

// File: rtl/nib_rx_select.sv
module nib_rx_select #(
   parameter int LANE_W = 4
) (
   input  logic              loop_i,
   input  logic [LANE_W-1:0] ext_nib_i,
   input  logic              ext_mark_i,
   input  logic [LANE_W-1:0] lb_nib_i,
   input  logic              lb_mark_i,
   output logic [LANE_W-1:0] nib_o,
   output logic              mark_o
);
   always_comb begin
      if (loop_i) begin
         nib_o  = lb_nib_i;
         mark_o = lb_mark_i;
      end else begin
         nib_o  = ext_nib_i;
         mark_o = ext_mark_i;
      end
   end
endmodule

// File: rtl/nib_rx_deframer.sv
module nib_rx_deframer
   import nib_link_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int LANE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LANE_W-1:0] nib_i,
   input  logic              mark_i,
   output logic [WORD_W-1:0] word_o,
   output logic              valid_o,
   output logic              err_o
);
   localparam int LANES = WORD_W / LANE_W;
   localparam int PH_W  = $clog2(LANES);
   localparam int REST_W = WORD_W - LANE_W;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(LANES - 1);

   rx_mode_e          mode_q;
   logic [PH_W-1:0]   ph_q;    // slot index of the next nibble
   logic [WORD_W-1:0] acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= RX_HUNT;
         ph_q    <= '0;
         acc_q   <= '0;
         word_o  <= '0;
         valid_o <= 1'b0;
         err_o   <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         err_o   <= 1'b0;
         if (mark_i) begin
            // early marker drops the partial word
            if (mode_q == RX_TRACK && ph_q != '0)
               err_o <= 1'b1;
            mode_q <= RX_TRACK;
            acc_q  <= {{REST_W{1'b0}}, nib_i};
            ph_q   <= PH_W'(1);
         end else if (mode_q == RX_TRACK) begin
            if (ph_q == '0) begin
               // marker due but absent
               err_o  <= 1'b1;
               mode_q <= RX_HUNT;
            end else if (ph_q == PH_LAST) begin
               word_o  <= {acc_q[REST_W-1:0], nib_i};
               valid_o <= 1'b1;
               ph_q    <= '0;
            end else begin
               acc_q <= {acc_q[REST_W-1:0], nib_i};
               ph_q  <= ph_q + 1'b1;
            end
         end
      end
   end

   // R9: valid is a single-cycle pulse
   p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);
   // R7: an alignment error never carries a word
   p_err_no_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !valid_o);
   // R6: hunting without a marker yields no word
   p_hunt_no_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == RX_HUNT && !mark_i) |=> !valid_o);

endmodule

// File: rtl/nib_word_link.sv
module nib_word_link #(
   parameter int WORD_W = 16,
   parameter int LANE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] tx_word_i,
   output logic              tx_fetch_o,
   output logic [LANE_W-1:0] cnv_txd_o,
   output logic              cnv_tx_mark_o,
   input  logic [LANE_W-1:0] cnv_rxd_i,
   input  logic              cnv_rx_mark_i,
   input  logic              loop_sel_i,
   output logic [WORD_W-1:0] rx_word_o,
   output logic              rx_valid_o,
   output logic              rx_align_err_o
);
   localparam int LANES = WORD_W / LANE_W;

   generate
      if (LANE_W < 1 || WORD_W % LANE_W != 0) begin : g_bad_lane
         $error("WORD_W must be a multiple of LANE_W");
      end
      if (LANES < 2) begin : g_bad_lanes
         $error("a word needs at least two nibble slots");
      end
   endgenerate

   logic [LANE_W-1:0] sel_nib;
   logic              sel_mark;

   nib_tx_serializer #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .word_i  (tx_word_i),
      .fetch_o (tx_fetch_o),
      .nib_o   (cnv_txd_o),
      .mark_o  (cnv_tx_mark_o)
   );

   nib_rx_select #(.LANE_W(LANE_W)) u_sel (
      .loop_i     (loop_sel_i),
      .ext_nib_i  (cnv_rxd_i),
      .ext_mark_i (cnv_rx_mark_i),
      .lb_nib_i   (cnv_txd_o),
      .lb_mark_i  (cnv_tx_mark_o),
      .nib_o      (sel_nib),
      .mark_o     (sel_mark)
   );

   nib_rx_deframer #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .nib_i   (sel_nib),
      .mark_i  (sel_mark),
      .word_o  (rx_word_o),
      .valid_o (rx_valid_o),
      .err_o   (rx_align_err_o)
   );

   // R4: in loopback an external marker alone starts no word
   p_loop_ext_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_sel_i && !cnv_tx_mark_o && cnv_rx_mark_i && !$past(cnv_tx_mark_o)
       && $past(rx_valid_o)) |=> !rx_align_err_o);

endmodule

// File: tb/nib_word_link_tb.sv
module nib_word_link_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] tx_word = '0;
   logic        tx_fetch;
   logic [3:0]  txd;
   logic        tx_mark;
   logic [3:0]  rxd = '0;
   logic        rx_mark = 1'b0;
   logic        loop_sel = 1'b0;
   logic [15:0] rx_word;
   logic        rx_valid;
   logic        rx_err;

   always #5 clk = ~clk;

   nib_word_link u_dut (
      .clk(clk), .rst_n(rst_n), .tx_word_i(tx_word), .tx_fetch_o(tx_fetch),
      .cnv_txd_o(txd), .cnv_tx_mark_o(tx_mark), .cnv_rxd_i(rxd),
      .cnv_rx_mark_i(rx_mark), .loop_sel_i(loop_sel), .rx_word_o(rx_word),
      .rx_valid_o(rx_valid), .rx_align_err_o(rx_err)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;
   string tag = "R1";

   // reference model state
   int          m_cyc;
   logic [4:0]  q_tx[$];         // {mark, nibble}
   logic [3:0]  e_txd;
   logic        e_mark;
   bit          m_lock;
   int          m_ph;
   int          m_acc;
   logic [15:0] e_word;
   logic        e_valid;
   logic        e_err;
   int          valid_seen;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s [%s] act=%0h exp=%0h t=%0t", req, tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_cyc = 0; q_tx.delete(); e_txd = '0; e_mark = 1'b0;
      m_lock = 0; m_ph = 0; m_acc = 0; e_word = '0; e_valid = 0; e_err = 0;
   endtask

   // predicts the outputs after the coming rising edge
   task automatic model_step();
      logic [3:0] sn;
      logic       sm;
      sn = loop_sel ? e_txd : rxd;
      sm = loop_sel ? e_mark : rx_mark;
      e_valid = 0;
      e_err = 0;
      if (sm) begin
         if (m_lock && m_ph != 0) e_err = 1;
         m_lock = 1; m_acc = sn; m_ph = 1;
      end else if (m_lock) begin
         if (m_ph == 0) begin
            e_err = 1; m_lock = 0;
         end else begin
            m_acc = (m_acc * 16 + sn) % 65536;
            if (m_ph == 3) begin
               e_valid = 1; e_word = m_acc[15:0]; m_ph = 0;
            end else m_ph++;
         end
      end
      if (m_cyc % 4 == 0)
         for (int k = 0; k < 4; k++)
            q_tx.push_back({k == 0, tx_word[15 - 4*k -: 4]});
      if (q_tx.size() > 0) begin
         {e_mark, e_txd} = q_tx.pop_front();
      end
      m_cyc++;
   endtask

   task automatic compare_all();
      chk("R2", tx_fetch, (m_cyc % 4 == 0));
      chk("R3", txd, e_txd);
      chk("R3", tx_mark, e_mark);
      chk("R5", rx_valid, e_valid);
      if (e_valid) chk("R5", rx_word, e_word);
      chk("R7/R8", rx_err, e_err);
      if (rx_valid) valid_seen++;
   endtask

   task automatic cyc(logic [3:0] xd, logic xm, logic lp);
      @(negedge clk);
      compare_all();
      tx_word = 16'($urandom);
      rxd = xd; rx_mark = xm; loop_sel = lp;
      model_step();
   endtask

   task automatic send_word(logic [15:0] w);
      for (int k = 0; k < 4; k++) cyc(w[15 - 4*k -: 4], k == 0, 1'b0);
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1", txd, 0); chk("R1", tx_mark, 0); chk("R1", rx_valid, 0);
      chk("R1", rx_err, 0); chk("R1", rx_word, 0);
      // release and prime the model for the first active edge
      @(negedge clk);
      rst_n = 1'b1;
      tx_word = 16'hA5C3;
      model_step();
      // first active cycle still shows reset values (R1)
      @(negedge clk);
      chk("R1", rx_valid, 0); chk("R1", rx_err, 0);
      compare_all();
      tx_word = 16'($urandom);
      model_step();

      tag = "R6";
      for (int i = 0; i < 12; i++) cyc(4'($urandom), 1'b0, 1'b0);

      tag = "R5";
      send_word(16'h1234);
      send_word(16'hFFFF);
      send_word(16'h0000);
      for (int i = 0; i < 4; i++) send_word(16'($urandom));

      tag = "R7";
      cyc(4'h9, 1'b1, 1'b0); cyc(4'h8, 1'b0, 1'b0);
      send_word(16'hBEEF);
      send_word(16'h5A5A);

      tag = "R8";
      send_word(16'hC001);
      for (int k = 0; k < 4; k++) cyc(4'h7, 1'b0, 1'b0);
      send_word(16'h0F0F);
      send_word(16'h4321);

      tag = "R9";
      for (int i = 0; i < 6; i++) cyc(4'h3, 1'b1, 1'b0);
      send_word(16'h6789);

      tag = "R4";
      valid_seen = 0;
      for (int i = 0; i < 48; i++) cyc(4'($urandom), 1'($urandom), 1'b1);
      n_cmp++;
      if (valid_seen < 8) begin
         n_bad++;
         $display("FAIL R4 loopback words act=%0d exp>=8", valid_seen);
      end
      tag = "R8";
      for (int i = 0; i < 8; i++) cyc(4'($urandom), 1'b0, 1'b0);

      @(negedge clk);
      compare_all();
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired act=running exp=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule